// File: doc/BRIEF.md
# Tapped Delay-Line Multiphase PWM Generator

This block drives N interleaved gate signals for a multiphase switching converter while computing only one pulse-width waveform. A modulo-R counter and a comparator form the base waveform, which is high for the first D cycles of every R-cycle switching period. That waveform is also the output for phase 0. Each clock it is pushed into a delay line of (N-1)·R/N stages. Phase i is read from the stage at depth i·R/N, so the phases are spread evenly over the period.

Adding a phase costs one more tap and no extra arithmetic. The length of the delay line follows the duty resolution R. The duty word is taken only when the counter wraps, so no period is ever cut short or stretched partway through. A new duty value appears on phase 0 at the next period boundary. It reaches phase i exactly i·R/N cycles later, because it travels down the same delay line.

Top module: `ilv_phase_interleaver`

## Requirements
- R1: With a duty value D where 0 < D < R, phase 0 is high for exactly D consecutive cycles at the start of each R-cycle period and low for the rest of the period.
- R2: In steady state, phase 0 has a rising edge every R clock cycles.
- R3: The duty input is captured only on the cycle where the period counter wraps from R-1 to 0. A change made in the middle of a period leaves the pulse of that period unchanged, even when the new value is below the current count.
- R4: Phase i (1 ≤ i < N) equals phase 0 delayed by exactly i·R/N clock cycles.
- R5: A duty value of 0 holds every phase low. Any duty value of R or more, up to the largest value the duty port can carry, holds every phase high once the delay line has filled.
- R6: After a duty step, phase i shows its first period with the new pulse width exactly i·R/N cycles after phase 0 does.
- R7: The synchronous active-high reset clears the counter, the held duty value and the delay line, so every phase is low during reset. Phase 0 first goes high on the R-th rising edge after reset is released, and phase i no earlier than i·R/N cycles after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one step of duty resolution |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | DUTY_W | Requested high time in clock cycles per period, captured at counter wrap |
| phase_o | output | NPH | Interleaved gate signals; bit 0 is the undelayed base waveform |

## Verification
A wrong counter or a wrong held duty value shows up on phase 0 within one period, as a pulse of the wrong width or an edge in the wrong place. A bad delay-line stage or a misplaced tap shows up only on the phases at or beyond that depth. It is seen as a mismatch against phase 0, shifted by the expected delay, within at most R cycles after the line has filled. For that reason the bench records every output sample and compares each phase with the history of phase 0. The duty-step tests check the period before the step and the period after it separately on every phase.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Depth in stages of the delay-line tap that feeds phase idx.
    function automatic int tap_depth(input int idx, input int space);
        return idx * space;
    endfunction

endpackage

// File: rtl/ilv_base_pwm.sv
module ilv_base_pwm #(
    parameter int RES    = 32,
    parameter int DUTY_W = $clog2(RES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);
    localparam int CW = (RES > 2) ? $clog2(RES) : 1;
    localparam logic [CW-1:0]     LAST    = CW'(RES - 1);
    localparam logic [DUTY_W-1:0] RES_VAL = DUTY_W'(RES);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [DUTY_W-1:0] duty;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.duty = duty_i;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = (DUTY_W'(st_q.cnt) < st_q.duty);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        DUTY_W'(st_q.cnt) < RES_VAL);                                  // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == LAST) |=> (st_q.cnt == '0));                      // R2
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != LAST) |=> $stable(st_q.duty));                    // R3
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q.duty == '0) |-> !pwm_o);                                 // R5
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st_q.duty >= RES_VAL) |-> pwm_o);                             // R5

endmodule

// File: rtl/ilv_delay_line.sv
module ilv_delay_line #(
    parameter int NTAP  = 3,
    parameter int SPACE = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            din,
    output logic [NTAP-1:0] taps_o
);
    localparam int LEN = NTAP * SPACE;

    typedef struct packed {
        logic [LEN-1:0] sr;
    } line_st_t;

    line_st_t st_d, st_q;
    logic [LEN-1:0] shifted;

    generate
        if (LEN > 1) begin : g_long
            assign shifted = {st_q.sr[LEN-2:0], din};
        end else begin : g_single
            assign shifted = din;
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        st_d.sr = shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NTAP; g++) begin : g_tap
            assign taps_o[g] = st_q.sr[ilv_pkg::tap_depth(g + 1, SPACE) - 1];
        end
    endgenerate

endmodule

// File: rtl/ilv_phase_interleaver.sv
module ilv_phase_interleaver #(
    parameter int NPH    = 4,
    parameter int RES    = 32,
    parameter int DUTY_W = $clog2(RES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [NPH-1:0]    phase_o
);
    localparam int SPACE = RES / NPH;
    localparam int NTAP  = NPH - 1;
    localparam logic [DUTY_W-1:0] RES_VAL   = DUTY_W'(RES);
    localparam logic [DUTY_W-1:0] SPACE_VAL = DUTY_W'(SPACE);

    logic            base_pwm;
    logic [NTAP-1:0] taps;

    ilv_base_pwm #(
        .RES    (RES),
        .DUTY_W (DUTY_W)
    ) u_base (
        .clk    (clk),
        .rst    (rst),
        .duty_i (duty_i),
        .pwm_o  (base_pwm)
    );

    ilv_delay_line #(
        .NTAP  (NTAP),
        .SPACE (SPACE)
    ) u_line (
        .clk    (clk),
        .rst    (rst),
        .din    (base_pwm),
        .taps_o (taps)
    );

    assign phase_o[0]     = base_pwm;
    assign phase_o[NPH-1:1] = taps;

    // Observation state for the guards below.
    typedef struct packed {
        logic [DUTY_W-1:0] fill;
        logic [DUTY_W-1:0] age;
        logic              p0;
        logic              p1;
    } obs_st_t;

    obs_st_t obs_d, obs_q;

    always_comb begin
        obs_d    = obs_q;
        obs_d.p0 = phase_o[0];
        obs_d.p1 = phase_o[1];
        if (obs_q.fill != RES_VAL) begin
            obs_d.fill = obs_q.fill + DUTY_W'(1);
        end
        if (phase_o[0] && !obs_q.p0) begin
            obs_d.age = DUTY_W'(1);
        end else if (obs_q.age != RES_VAL) begin
            obs_d.age = obs_q.age + DUTY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            obs_q      <= '0;
            obs_q.age  <= RES_VAL;
        end else begin
            obs_q <= obs_d;
        end
    end

    AST_FILL_LOW: assert property (@(posedge clk) disable iff (rst)
        (obs_q.fill < RES_VAL) |-> (phase_o == '0));                   // R7
    AST_TAP1_SPACING: assert property (@(posedge clk) disable iff (rst)
        (phase_o[1] && !obs_q.p1) |-> (obs_q.age == SPACE_VAL));       // R4

endmodule

// File: tb/ilv_phase_interleaver_test.sv
module ilv_phase_interleaver_test;
    localparam int NPH = 4;
    localparam int RES = 32;
    localparam int DW  = $clog2(RES + 1);
    localparam int SP  = RES / NPH;
    localparam int LEN = (NPH - 1) * SP;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [DW-1:0]  duty = '0;
    logic [NPH-1:0] ph;

    int checks = 0;
    int fails  = 0;
    int t      = 0;
    bit done   = 1'b0;
    logic [NPH-1:0] hist [0:16383];

    ilv_phase_interleaver #(.NPH(NPH), .RES(RES)) uut (
        .clk(clk), .rst(rst), .duty_i(duty), .phase_o(ph)
    );

    always #2 clk = ~clk;

    // Sample index j holds the outputs after the (j+1)-th edge past reset release.
    always @(negedge clk) begin
        if (!rst) begin
            hist[t] = ph;
            t = t + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic int highs(input int idx, input int from, input int n);
        int c = 0;
        for (int k = from; k < from + n; k++) c += int'(hist[k][idx]);
        return c;
    endfunction

    task automatic test_reset();
        duty = DW'(RES);
        wait_cyc(4);
        chk(ph == '0, "R7 outputs low in reset", int'(ph), 0);
        rst = 1'b0;
        wait_cyc(RES + LEN + 4);
        chk(highs(0, 0, RES - 1) == 0, "R7 phase0 low before edge R", highs(0, 0, RES - 1), 0);
        for (int i = 0; i < NPH; i++) begin
            chk(hist[RES - 2 + i * SP][i] == 1'b0, "R7 phase still low before tap fill", 1, 0);
            chk(hist[RES - 1 + i * SP][i] == 1'b1, "R7 R4 phase rises after tap delay", 0, 1);
        end
    endtask

    task automatic test_level(input int d, input bit lvl);
        duty = DW'(d);
        wait_cyc(2 * RES + LEN + 2);
        for (int i = 0; i < NPH; i++) begin
            chk(highs(i, t - RES, RES) == (lvl ? RES : 0), "R5 level duty",
                highs(i, t - RES, RES), lvl ? RES : 0);
        end
    endtask

    task automatic test_pwm(input int d);
        int k0;
        int mis;
        duty = DW'(d);
        wait_cyc(3 * RES + LEN);
        k0 = -1;
        for (int k = t - 2 * RES; k < t - RES; k++) begin
            if (k0 < 0 && hist[k][0] && !hist[k - 1][0]) k0 = k;
        end
        chk(k0 >= 0, "R2 phase0 rising edge found", k0, 0);
        if (k0 >= 0) begin
            chk(highs(0, k0, RES) == d, "R1 high cycles per period", highs(0, k0, RES), d);
            chk(hist[k0 + d - 1][0] && !hist[k0 + d][0], "R1 pulse contiguous from period start",
                int'(hist[k0 + d][0]), 0);
            chk(hist[k0 + RES][0] && !hist[k0 + RES - 1][0], "R2 next rise after R cycles",
                int'(hist[k0 + RES][0]), 1);
        end
        for (int i = 1; i < NPH; i++) begin
            mis = 0;
            for (int j = t - RES; j < t; j++) begin
                if (hist[j][i] != hist[j - i * SP][0]) mis++;
            end
            chk(mis == 0, "R4 phase equals delayed phase0", mis, 0);
        end
    endtask

    task automatic test_step(input int d1, input int d2);
        int tr;
        duty = DW'(d1);
        wait_cyc(3 * RES + LEN);
        tr = -1;
        while (tr < 0) begin
            wait_cyc(1);
            if (hist[t - 1][0] && !hist[t - 2][0]) tr = t - 1;
        end
        wait_cyc(5);
        duty = DW'(d2);
        wait_cyc(2 * RES + LEN + 2);
        for (int i = 0; i < NPH; i++) begin
            chk(highs(i, tr + i * SP, RES) == d1, "R3 R6 old width kept in step period",
                highs(i, tr + i * SP, RES), d1);
            chk(highs(i, tr + RES + i * SP, RES) == d2, "R6 new width after tap delay",
                highs(i, tr + RES + i * SP, RES), d2);
        end
    endtask

    initial begin
        test_reset();
        test_pwm(1);
        test_pwm(13);
        test_pwm(RES - 1);
        test_level(0, 1'b0);
        test_level(RES, 1'b1);
        test_level((1 << DW) - 1, 1'b1);
        test_step(8, 25);
        test_step(20, 3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule